// File: doc/BRIEF.md
# I/O MMU Control and Fault Register Block

This block is the register file and control state of an I/O memory management unit. Software reaches it over a simple single-cycle read/write bus. Through it, software turns translation on and off, asks the traffic path to stall, and programs the page table base and a masked configuration word. It also issues TLB flushes, either of the whole TLB or of one page. Address translation itself is done elsewhere. This block only drives the enable, stall and flush controls toward that logic.

The translation path reports faults on a one-cycle event port that carries a 3-bit kind and the faulting address. Each kind sets its own pending bit and raises the interrupt line. The address is captured into one of four fault address registers, chosen by the kind. A fault also puts the unit into the stall mode by itself. The service routine reads the status word, which reports the lowest pending kind, handles that kind, and acknowledges it by writing a one to its bit.

Top module: `iommu_ctrl_regs`

## Requirements
- R1: Writing exactly 0x5 to the control register (offset 0x000) gives run mode (xlate_en_o=1, block_o=0). Writing exactly 0x7 gives stall mode (xlate_en_o=1, block_o=1). Writing exactly 0x0 gives off mode (both outputs 0). Any other value leaves the mode unchanged. The control register reads back the current mode code.
- R2: Status bit 0 (offset 0x008) is updated at every clock edge. It becomes 1 when the mode after that edge is stall mode and either idle_i is 1 or the bit was already 1. Otherwise it becomes 0. Once set in stall mode, it stays 1 even if idle_i later drops.
- R3: A fault event of kind k (0..7) sets bit k of the interrupt status register (offset 0x018). irq_o is 1 whenever any interrupt status bit is 1.
- R4: The fault address is captured in a fault address register chosen by kind. Kind 0 goes to offset 0x024. Kind 3 goes to offset 0x030. Kinds 2, 6 and 7 go to offset 0x028. Kinds 1, 4 and 5 go to offset 0x02C.
- R5: A fault address register is written only when the status bit of the reporting kind was 0 before the event. A repeat fault of a kind that is still pending leaves the captured address unchanged.
- R6: A fault event switches the unit to stall mode (control reads 0x7). This takes priority over a control write in the same cycle.
- R7: Writing a value to the interrupt clear register (offset 0x01C) clears every status bit that has a 1 in the same position. A fault arriving in the same cycle as a clear of its bit leaves that bit set.
- R8: Status bits [6:4] hold the index of the lowest set interrupt status bit, and status bit 7 is 1 when any bit is set. With nothing pending, bits [7:4] are 0.
- R9: The version register (offset 0x034) holds the major version in bits [31:28] and the minor version in bits [27:21]. All other bits are 0.
- R10: The configuration register (offset 0x004) stores only bits 0-15, 20, 22 and 24 of a write. All other bits read 0.
- R11: A write to the table base register (offset 0x014) stores bits [31:14], and the low bits read 0. It also pulses flush_all_o high for the one cycle after the write. A write to the full flush register (offset 0x00C) with bit 0 = 1 pulses flush_all_o in the same way. With bit 0 = 0 it does nothing.
- R12: A write to the entry flush register (offset 0x010) with bit 0 = 1 pulses flush_entry_o for the one cycle after the write. In that cycle, flush_entry_addr_o holds the written value with bits [11:0] cleared. With bit 0 = 0 there is no pulse.
- R13: After reset, the mode is off, all status and interrupt bits are 0, and the configuration and table base registers read 0.
- R14: Reads of unmapped offsets return 0. Writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_we_i | input | 1 | Register write strobe |
| req_addr_i | input | ADDR_W | Register byte offset |
| req_wdata_i | input | 32 | Write data |
| rsp_rdata_o | output | 32 | Read data for req_addr_i (combinational) |
| flt_valid_i | input | 1 | Fault event strobe |
| flt_kind_i | input | 3 | Fault kind 0..7 |
| flt_addr_i | input | 32 | Faulting address |
| idle_i | input | 1 | Traffic path has no outstanding requests |
| irq_o | output | 1 | Fault interrupt |
| xlate_en_o | output | 1 | Translation enabled |
| block_o | output | 1 | Stall new traffic |
| flush_all_o | output | 1 | Full TLB flush pulse |
| flush_entry_o | output | 1 | Single-page TLB flush pulse |
| flush_entry_addr_o | output | 32 | Page address for the entry flush |

## Verification
The bench sweeps all eight fault kinds. For each kind it checks the pending bit, the routed address register, the forced stall mode, and that a repeated fault does not overwrite the captured address. A routing table that mixed up the read and write sides, or that overwrote on a repeat, would show the wrong address. It checks that the lowest pending index moves upward as bits are acknowledged one by one, which catches a priority encoder scanning from the wrong end. It also drives a fault and the clear of the same bit in one cycle, and a fault and a control write in one cycle. A design where the clear or the software write wins would lose the fault or leave stall mode. It sweeps walking ones through the configuration register, writes non-code values to control, and checks that the stall handshake bit holds once idle drops.

// File: rtl/iommu_ctrl_pkg.sv
package iommu_ctrl_pkg;
  localparam int unsigned NUM_KINDS = 8;
  localparam int unsigned KIND_W    = $clog2(NUM_KINDS);
  localparam int unsigned NUM_SLOTS = 4;
  localparam int unsigned SLOT_W    = $clog2(NUM_SLOTS);

  localparam logic [11:0] OFF_CTRL  = 12'h000;
  localparam logic [11:0] OFF_CFG   = 12'h004;
  localparam logic [11:0] OFF_STAT  = 12'h008;
  localparam logic [11:0] OFF_FLALL = 12'h00C;
  localparam logic [11:0] OFF_FLENT = 12'h010;
  localparam logic [11:0] OFF_BASE  = 12'h014;
  localparam logic [11:0] OFF_ISTAT = 12'h018;
  localparam logic [11:0] OFF_ICLR  = 12'h01C;
  localparam logic [11:0] OFF_APAGE = 12'h024;
  localparam logic [11:0] OFF_AWR   = 12'h028;
  localparam logic [11:0] OFF_ARD   = 12'h02C;
  localparam logic [11:0] OFF_ADFLT = 12'h030;
  localparam logic [11:0] OFF_VER   = 12'h034;

  localparam logic [31:0] CFG_KEEP  = 32'h0150_FFFF;

  typedef enum logic [2:0] {
    MODE_OFF  = 3'd0,
    MODE_RUN  = 3'd5,
    MODE_HOLD = 3'd7
  } mode_e;

  // slot index order matches fault address register order
  localparam logic [SLOT_W-1:0] SLOT_PAGE = 2'd0;
  localparam logic [SLOT_W-1:0] SLOT_WR   = 2'd1;
  localparam logic [SLOT_W-1:0] SLOT_RD   = 2'd2;
  localparam logic [SLOT_W-1:0] SLOT_DFLT = 2'd3;

  function automatic logic [SLOT_W-1:0] route_of(input logic [KIND_W-1:0] kind);
    case (kind)
      3'd0:             return SLOT_PAGE;
      3'd3:             return SLOT_DFLT;
      3'd2, 3'd6, 3'd7: return SLOT_WR;
      default:          return SLOT_RD;
    endcase
  endfunction
endpackage

// File: rtl/iommu_ctrl_mode.sv
module iommu_ctrl_mode
  import iommu_ctrl_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  input  logic        fault_i,
  input  logic        idle_i,
  output mode_e       mode_o,
  output logic        blocked_o
);
  mode_e mode_q, mode_d;
  logic  blocked_q;

  always_comb begin
    mode_d = mode_q;
    if (fault_i) begin
      mode_d = MODE_HOLD;
    end else if (wr_i) begin
      case (wdata_i)
        32'h0:   mode_d = MODE_OFF;
        32'h5:   mode_d = MODE_RUN;
        32'h7:   mode_d = MODE_HOLD;
        default: mode_d = mode_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= MODE_OFF;
      blocked_q <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      blocked_q <= (mode_d == MODE_HOLD) && (blocked_q || idle_i);
    end
  end

  assign mode_o    = mode_q;
  assign blocked_o = blocked_q;
endmodule

// File: rtl/iommu_fault_unit.sv
module iommu_fault_unit
  import iommu_ctrl_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           flt_valid_i,
  input  logic [KIND_W-1:0]              flt_kind_i,
  input  logic [AW-1:0]                  flt_addr_i,
  input  logic                           clr_we_i,
  input  logic [NUM_KINDS-1:0]           clr_mask_i,
  output logic [NUM_KINDS-1:0]           status_o,
  output logic [NUM_SLOTS-1:0][AW-1:0]   slot_addr_o,
  output logic                           pend_any_o,
  output logic [KIND_W-1:0]              pend_idx_o
);
  logic [NUM_KINDS-1:0] status_q, set_vec, clr_vec;
  logic [SLOT_W-1:0]    slot_sel;
  logic                 capture;

  assign set_vec  = flt_valid_i ? (NUM_KINDS'(1) << flt_kind_i) : '0;
  assign clr_vec  = clr_we_i ? clr_mask_i : '0;
  assign slot_sel = route_of(flt_kind_i);
  assign capture  = flt_valid_i && !status_q[flt_kind_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_vec) | set_vec;
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [AW-1:0] addr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr_q <= '0;
      end else if (capture && (slot_sel == SLOT_W'(s))) begin
        addr_q <= flt_addr_i;
      end
    end
    assign slot_addr_o[s] = addr_q;
  end

  // lowest pending kind is reported first
  always_comb begin
    pend_idx_o = '0;
    for (int i = NUM_KINDS - 1; i >= 0; i--) begin
      if (status_q[i]) pend_idx_o = KIND_W'(i);
    end
  end

  assign pend_any_o = |status_q;
  assign status_o   = status_q;
endmodule

// File: rtl/iommu_flush_gen.sv
module iommu_flush_gen #(
  parameter int unsigned PAGE_SHIFT = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  base_wr_i,
  input  logic                  all_wr_i,
  input  logic                  entry_wr_i,
  input  logic                  go_i,
  input  logic [31-PAGE_SHIFT:0] page_i,
  output logic                  flush_all_o,
  output logic                  flush_entry_o,
  output logic [31:0]           entry_addr_o
);
  logic                   all_q, ent_q;
  logic [31-PAGE_SHIFT:0] page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      all_q  <= 1'b0;
      ent_q  <= 1'b0;
      page_q <= '0;
    end else begin
      all_q <= base_wr_i | (all_wr_i & go_i);
      ent_q <= entry_wr_i & go_i;
      if (entry_wr_i && go_i) page_q <= page_i;
    end
  end

  assign flush_all_o   = all_q;
  assign flush_entry_o = ent_q;
  assign entry_addr_o  = {page_q, {PAGE_SHIFT{1'b0}}};
endmodule

// File: rtl/iommu_ctrl_regs.sv
module iommu_ctrl_regs
  import iommu_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned VER_MAJOR  = 3,
  parameter int unsigned VER_MINOR  = 3,
  parameter int unsigned BASE_ALIGN = 14,
  parameter int unsigned PAGE_SHIFT = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [31:0]       req_wdata_i,
  output logic [31:0]       rsp_rdata_o,
  input  logic              flt_valid_i,
  input  logic [2:0]        flt_kind_i,
  input  logic [31:0]       flt_addr_i,
  input  logic              idle_i,
  output logic              irq_o,
  output logic              xlate_en_o,
  output logic              block_o,
  output logic              flush_all_o,
  output logic              flush_entry_o,
  output logic [31:0]       flush_entry_addr_o
);
  localparam logic [31:0] VER_WORD = {4'(VER_MAJOR), 7'(VER_MINOR), 21'b0};

  logic sel_ctrl, sel_cfg, sel_stat, sel_flall, sel_flent, sel_base;
  logic sel_istat, sel_iclr, sel_apage, sel_awr, sel_ard, sel_adflt, sel_ver;

  assign sel_ctrl  = req_addr_i == ADDR_W'(OFF_CTRL);
  assign sel_cfg   = req_addr_i == ADDR_W'(OFF_CFG);
  assign sel_stat  = req_addr_i == ADDR_W'(OFF_STAT);
  assign sel_flall = req_addr_i == ADDR_W'(OFF_FLALL);
  assign sel_flent = req_addr_i == ADDR_W'(OFF_FLENT);
  assign sel_base  = req_addr_i == ADDR_W'(OFF_BASE);
  assign sel_istat = req_addr_i == ADDR_W'(OFF_ISTAT);
  assign sel_iclr  = req_addr_i == ADDR_W'(OFF_ICLR);
  assign sel_apage = req_addr_i == ADDR_W'(OFF_APAGE);
  assign sel_awr   = req_addr_i == ADDR_W'(OFF_AWR);
  assign sel_ard   = req_addr_i == ADDR_W'(OFF_ARD);
  assign sel_adflt = req_addr_i == ADDR_W'(OFF_ADFLT);
  assign sel_ver   = req_addr_i == ADDR_W'(OFF_VER);

  mode_e                         mode;
  logic                          blocked;
  logic [NUM_KINDS-1:0]          int_status;
  logic [NUM_SLOTS-1:0][31:0]    slot_addr;
  logic                          pend_any;
  logic [KIND_W-1:0]             pend_idx;
  logic [31:0]                   cfg_q;
  logic [31-BASE_ALIGN:0]        base_q;

  iommu_ctrl_mode u_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (req_we_i && sel_ctrl),
    .wdata_i   (req_wdata_i),
    .fault_i   (flt_valid_i),
    .idle_i    (idle_i),
    .mode_o    (mode),
    .blocked_o (blocked)
  );

  iommu_fault_unit #(.AW(32)) u_fault (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flt_valid_i (flt_valid_i),
    .flt_kind_i  (flt_kind_i),
    .flt_addr_i  (flt_addr_i),
    .clr_we_i    (req_we_i && sel_iclr),
    .clr_mask_i  (req_wdata_i[NUM_KINDS-1:0]),
    .status_o    (int_status),
    .slot_addr_o (slot_addr),
    .pend_any_o  (pend_any),
    .pend_idx_o  (pend_idx)
  );

  iommu_flush_gen #(.PAGE_SHIFT(PAGE_SHIFT)) u_flush (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .base_wr_i     (req_we_i && sel_base),
    .all_wr_i      (req_we_i && sel_flall),
    .entry_wr_i    (req_we_i && sel_flent),
    .go_i          (req_wdata_i[0]),
    .page_i        (req_wdata_i[31:PAGE_SHIFT]),
    .flush_all_o   (flush_all_o),
    .flush_entry_o (flush_entry_o),
    .entry_addr_o  (flush_entry_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      base_q <= '0;
    end else if (req_we_i) begin
      if (sel_cfg)  cfg_q  <= req_wdata_i & CFG_KEEP;
      if (sel_base) base_q <= req_wdata_i[31:BASE_ALIGN];
    end
  end

  always_comb begin
    rsp_rdata_o = '0;
    unique if (sel_ctrl)  rsp_rdata_o = {29'b0, mode};
    else if (sel_cfg)     rsp_rdata_o = cfg_q;
    else if (sel_stat)    rsp_rdata_o = {24'b0, pend_any, pend_idx, 3'b0, blocked};
    else if (sel_base)    rsp_rdata_o = {base_q, {BASE_ALIGN{1'b0}}};
    else if (sel_istat)   rsp_rdata_o = {{(32-NUM_KINDS){1'b0}}, int_status};
    else if (sel_apage)   rsp_rdata_o = slot_addr[SLOT_PAGE];
    else if (sel_awr)     rsp_rdata_o = slot_addr[SLOT_WR];
    else if (sel_ard)     rsp_rdata_o = slot_addr[SLOT_RD];
    else if (sel_adflt)   rsp_rdata_o = slot_addr[SLOT_DFLT];
    else if (sel_ver)     rsp_rdata_o = VER_WORD;
    else                  rsp_rdata_o = '0;
  end

  assign irq_o      = pend_any;
  assign xlate_en_o = mode != MODE_OFF;
  assign block_o    = mode == MODE_HOLD;
endmodule

// File: rtl/iommu_ctrl_chk.sv
module iommu_ctrl_chk #(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_we_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [31:0]       req_wdata_i,
  input logic              flt_valid_i,
  input logic              irq_o,
  input logic              xlate_en_o,
  input logic              block_o,
  input logic              flush_all_o,
  input logic              blocked,
  input logic [7:0]        int_status,
  input logic [31:0]       page_addr
);
  import iommu_ctrl_pkg::*;

  AST_FAULT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_valid_i |=> (block_o && xlate_en_o)); // R6

  AST_FAULT_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_valid_i |=> irq_o); // R3

  AST_BLOCKED_IN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blocked |-> block_o); // R2

  AST_HOLD_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_o |-> xlate_en_o); // R1

  AST_FLUSH_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all_o |-> $past(req_we_i && ((req_addr_i == ADDR_W'(OFF_BASE)) ||
                          ((req_addr_i == ADDR_W'(OFF_FLALL)) && req_wdata_i[0])))); // R11

  AST_PAGE_ADDR_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(int_status[0]) && int_status[0]) |-> $stable(page_addr)); // R5
endmodule

bind iommu_ctrl_regs iommu_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_we_i    (req_we_i),
  .req_addr_i  (req_addr_i),
  .req_wdata_i (req_wdata_i),
  .flt_valid_i (flt_valid_i),
  .irq_o       (irq_o),
  .xlate_en_o  (xlate_en_o),
  .block_o     (block_o),
  .flush_all_o (flush_all_o),
  .blocked     (blocked),
  .int_status  (int_status),
  .page_addr   (slot_addr[0])
);

// File: tb/sim_iommu_ctrl_regs.sv
`timescale 1ns/1ps
module sim_iommu_ctrl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        fv = 1'b0;
  logic [2:0]  fk = '0;
  logic [31:0] fa = '0;
  logic        idle = 1'b1;
  logic        irq, xen, blk, fall, fent;
  logic [31:0] fent_addr;
  int          n_tests = 0;
  int          n_fail = 0;
  logic [31:0] v;

  always #2.5 clk = ~clk;

  iommu_ctrl_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_we_i(we), .req_addr_i(addr),
    .req_wdata_i(wdata), .rsp_rdata_o(rdata), .flt_valid_i(fv),
    .flt_kind_i(fk), .flt_addr_i(fa), .idle_i(idle), .irq_o(irq),
    .xlate_en_o(xen), .block_o(blk), .flush_all_o(fall),
    .flush_entry_o(fent), .flush_entry_addr_o(fent_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic fault(input logic [2:0] k, input logic [31:0] a);
    @(negedge clk); fv = 1'b1; fk = k; fa = a;
    @(negedge clk); fv = 1'b0;
  endtask

  function automatic logic [11:0] route_off(input int k);
    if (k == 0) return 12'h024;
    if (k == 3) return 12'h030;
    if (k == 2 || k == 6 || k == 7) return 12'h028;
    return 12'h02C;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R13 reset state
    rd(12'h000, v); chk("R13 ctrl", v, 32'h0);
    rd(12'h008, v); chk("R13 status", v, 32'h0);
    rd(12'h018, v); chk("R13 istat", v, 32'h0);
    rd(12'h004, v); chk("R13 cfg", v, 32'h0);
    rd(12'h014, v); chk("R13 base", v, 32'h0);
    chk("R13 outs", {irq, xen, blk, fall, fent}, 32'h0);

    // R9 version
    rd(12'h034, v); chk("R9 version", v, (32'd3 << 28) | (32'd3 << 21));

    // R14 unmapped
    wr(12'h020, 32'hFFFF_FFFF); rd(12'h020, v); chk("R14 hole 020", v, 32'h0);
    wr(12'h038, 32'h5);         rd(12'h038, v); chk("R14 hole 038", v, 32'h0);
    rd(12'h000, v); chk("R14 ctrl untouched", v, 32'h0);
    rd(12'h004, v); chk("R14 cfg untouched", v, 32'h0);

    // R1 control encoding
    wr(12'h000, 32'h5); chk("R1 run outs", {xen, blk}, 32'h2);
    rd(12'h000, v); chk("R1 run code", v, 32'h5);
    wr(12'h000, 32'h3); rd(12'h000, v); chk("R1 bad code ignored", v, 32'h5);
    wr(12'h000, 32'h105); rd(12'h000, v); chk("R1 wide code ignored", v, 32'h5);
    wr(12'h000, 32'h7); chk("R1 hold outs", {xen, blk}, 32'h3);
    wr(12'h000, 32'h0); chk("R1 off outs", {xen, blk}, 32'h0);

    // R2 block handshake
    idle = 1'b0;
    wr(12'h000, 32'h7);
    rd(12'h008, v); chk("R2 not drained", v & 32'h1, 32'h0);
    idle = 1'b1;
    rd(12'h008, v); chk("R2 drained", v & 32'h1, 32'h1);
    idle = 1'b0;
    rd(12'h008, v); chk("R2 sticky", v & 32'h1, 32'h1);
    wr(12'h000, 32'h5);
    rd(12'h008, v); chk("R2 left hold", v & 32'h1, 32'h0);
    idle = 1'b1;
    rd(12'h008, v); chk("R2 idle in run", v & 32'h1, 32'h0);

    // R10 config mask sweep
    for (int i = 0; i < 32; i++) begin
      wr(12'h004, 32'h1 << i); rd(12'h004, v);
      chk("R10 walk", v, (32'h1 << i) & 32'h0150_FFFF);
    end
    wr(12'h004, 32'hFFFF_FFFF); rd(12'h004, v); chk("R10 ones", v, 32'h0150_FFFF);
    wr(12'h004, 32'hA5A5_A5A5); rd(12'h004, v); chk("R10 a5", v, 32'hA5A5_A5A5 & 32'h0150_FFFF);

    // R11 table base and full flush
    wr(12'h014, 32'h1234_5678); chk("R11 base flush pulse", fall, 1'b1);
    rd(12'h014, v); chk("R11 base value", v, 32'h1234_4000);
    chk("R11 pulse one cycle", fall, 1'b0);
    wr(12'h00C, 32'h1); chk("R11 full flush", fall, 1'b1);
    wr(12'h00C, 32'h0); chk("R11 no flush bit0=0", fall, 1'b0);

    // R12 entry flush
    wr(12'h010, 32'hABCD_E123);
    chk("R12 entry pulse", fent, 1'b1);
    chk("R12 entry addr", fent_addr, 32'hABCD_E000);
    wr(12'h010, 32'h1111_1122); chk("R12 no pulse bit0=0", fent, 1'b0);
    chk("R12 no full flush", fall, 1'b0);

    // R3 R4 R5 R6 R7 R8 sweep of all kinds
    idle = 1'b1;
    for (int k = 0; k < 8; k++) begin
      logic [31:0] a1, a2;
      a1 = 32'h1000_0111 + (k << 20);
      a2 = 32'h7777_0000 + k;
      wr(12'h000, 32'h5);
      fault(3'(k), a1);
      chk("R3 irq", irq, 1'b1);
      rd(12'h018, v); chk("R3 status bit", v, 32'h1 << k);
      rd(12'h000, v); chk("R6 forced hold", v, 32'h7);
      rd(route_off(k), v); chk("R4 routed addr", v, a1);
      rd(12'h008, v); chk("R8 lowest", v, 32'h81 | (k << 4));
      fault(3'(k), a2);
      rd(route_off(k), v); chk("R5 no overwrite", v, a1);
      wr(12'h01C, 32'h1 << k);
      rd(12'h018, v); chk("R7 cleared", v, 32'h0);
      chk("R3 irq low", irq, 1'b0);
    end

    // R8 lowest first across several pending
    fault(3'd7, 32'h70); fault(3'd5, 32'h50); fault(3'd2, 32'h20);
    rd(12'h008, v); chk("R8 idx 2", v & 32'hF0, 32'hA0);
    wr(12'h01C, 32'h04); rd(12'h008, v); chk("R8 idx 5", v & 32'hF0, 32'hD0);
    wr(12'h01C, 32'h20); rd(12'h008, v); chk("R8 idx 7", v & 32'hF0, 32'hF0);
    wr(12'h01C, 32'h80); rd(12'h008, v); chk("R8 none", v & 32'hF0, 32'h00);

    // R7 set wins over clear in the same cycle
    @(negedge clk); we = 1'b1; addr = 12'h01C; wdata = 32'h08; fv = 1'b1; fk = 3'd3; fa = 32'hDEAD_0000;
    @(negedge clk); we = 1'b0; fv = 1'b0;
    rd(12'h018, v); chk("R7 set wins", v, 32'h08);
    wr(12'h01C, 32'hFF); rd(12'h018, v); chk("R7 clear all", v, 32'h0);

    // R6 fault beats control write
    @(negedge clk); we = 1'b1; addr = 12'h000; wdata = 32'h0; fv = 1'b1; fk = 3'd0; fa = 32'h4;
    @(negedge clk); we = 1'b0; fv = 1'b0;
    rd(12'h000, v); chk("R6 fault priority", v, 32'h7);
    wr(12'h01C, 32'h01);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule